// File: doc/BRIEF.md
# Coalescing miss-tracking file

A small file of miss-tracking entries that sits beside a non-blocking L1 data cache. Each load presents a byte address, an instruction tag counted from the current retire point, and a flag saying whether this is its first issue. In the same cycle the block answers with one of four outcomes. A hit takes the cache hit latency. A merge joins an outstanding miss to the same line and reports that miss's remaining time. An allocation claims a fresh entry and reports its completion delay. An abort reports that no entry could be taken and gives the number of cycles until the nearest busy entry finishes.

The write buffer supplies a conflict summary for the load's line: whether an equal-or-older store is pending, the age of the newest such store, and the absolute cycle at which the last of them completes. The tag-store lookup result and the L2 lookup result arrive as plain inputs. Entries are shared through a reference count. Each holder gives its reference back through a release port. When an entry's completion cycle arrives, the block emits a one-cycle done pulse with the entry index and the line address, which is used to fill the tag stores.

Top module: `mshr_file`

## Requirements
- R1: Addresses are compared and stored with the low OFF_W bits cleared, so any two addresses in one line of 2^OFF_W bytes (64 by default) refer to the same entry, and done_addr_o always has those bits at zero.
- R2: rsp_kind_o is coded 0 hit, 1 merge, 2 allocate, 3 abort. A load with l1_hit_i high and st_hit_i low is answered as a hit with delay HIT_LAT and takes no entry.
- R3: On a miss, the load merges into the lowest-index busy entry that has the same line and an age not newer than the load's own age. When st_hit_i is high, entries whose age is below st_age_i are skipped. The reported delay is that entry's remaining time to completion, or 0 once that time has passed.
- R4: An entry's age is ((tag + retire base at allocation) mod 256) minus the current retire_base_i, folded into -128..+128. A load's age is req_tag_i folded the same way.
- R5: With st_hit_i high a load never takes the hit path. A new entry starts waiting, and its first deadline is the later of st_done_at_i and the next cycle. When that deadline arrives the entry starts its L1 miss phase without giving a done pulse.
- R6: With no store conflict, a new entry is placed in the lowest free index and completes L1_LAT cycles later if l2_hit_i is high, or L1_LAT+L2_LAT cycles later if it is low. That delay is reported.
- R7: A load with req_first_i low is not allowed to allocate when one or no entry is free. A load with req_first_i high may take the last free entry.
- R8: A load that cannot merge or allocate gets kind 3 and a delay equal to the smallest remaining time among all busy entries.
- R9: Allocation sets the reference count to one, each merge adds one, each release through rel_valid_i/rel_idx_i takes one away, and the entry is freed when its count reaches zero.
- R10: An entry freed by a release is not handed to a load in the cycle of that release. It is free from the following cycle.
- R11: When the cycle counter reaches a non-waiting entry's completion time, done_o is high for exactly one cycle with that index and line address. If several entries are due, the lowest index goes first.
- R12: After reset every entry is free, the cycle counter is zero and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Load request present this cycle |
| req_addr_i | input | ADDR_W | Load byte address |
| req_tag_i | input | TAG_W | Load position counted from the current retire base |
| req_first_i | input | 1 | High on first issue, low on re-issue |
| l1_hit_i | input | 1 | Tag-store lookup found the line |
| l2_hit_i | input | 1 | L2 lookup found the line |
| st_hit_i | input | 1 | An equal-or-older store to the same line is pending |
| st_age_i | input | TAG_W+2 | Folded age of the newest such store (two's complement) |
| st_done_at_i | input | CYC_W | Absolute cycle at which the last such store completes |
| retire_base_i | input | TAG_W | Current retire base |
| rel_valid_i | input | 1 | Give back one reference |
| rel_idx_i | input | IDX_W | Entry whose reference is returned |
| rsp_kind_o | output | 2 | Outcome: 0 hit, 1 merge, 2 allocate, 3 abort |
| rsp_idx_o | output | IDX_W | Entry merged into or allocated |
| rsp_delay_o | output | CYC_W | Cycles until data, or until the nearest entry frees on abort |
| done_o | output | 1 | One-cycle completion pulse |
| done_idx_o | output | IDX_W | Completing entry |
| done_addr_o | output | ADDR_W | Line address of the completing entry |

## Verification
The bench targets tag-window wrap. An entry allocated just before the retire base wraps must still rank as older than a later load, and a negative-folded tag must refuse to merge into a younger entry. A design that compared raw tags would merge across that boundary. It also targets freeing: a release that drops the count to zero must not free the entry for a load in that same cycle, and a merge must keep the entry alive. Getting either wrong shows up as a different index or kind in the reply. The bench further covers the re-issue rule on the last free entry, the abort delay taken from the oldest busy entry, and store-conflicted loads that must neither hit nor pulse done when the store wait ends. A design that ignored the wait would pulse four cycles early.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    RSP_HIT   = 2'd0,
    RSP_MERGE = 2'd1,
    RSP_ALLOC = 2'd2,
    RSP_ABORT = 2'd3
  } rsp_kind_e;
endpackage

// File: rtl/mshr_age_fold.sv
module mshr_age_fold #(
  parameter int TAG_W = 8
) (
  input  logic [TAG_W-1:0]        pos_i,
  input  logic [TAG_W-1:0]        base_i,
  output logic signed [TAG_W+1:0] age_o
);
  localparam logic signed [TAG_W+1:0] HALF = (TAG_W+2)'(2**(TAG_W-1));
  localparam logic signed [TAG_W+1:0] SPAN = (TAG_W+2)'(2**TAG_W);

  logic signed [TAG_W+1:0] diff;

  always_comb begin
    diff = $signed({2'b00, pos_i}) - $signed({2'b00, base_i});
    if (diff > HALF)       age_o = diff - SPAN;
    else if (diff < -HALF) age_o = diff + SPAN;
    else                   age_o = diff;
  end
endmodule

// File: rtl/mshr_lsb_pick.sv
module mshr_lsb_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mshr_min_rem.sv
module mshr_min_rem #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic [N-1:0] valid_i,
  input  logic [W-1:0] val_i [N],
  output logic [W-1:0] min_o
);
  always_comb begin
    min_o = '1;
    for (int i = 0; i < N; i++) begin
      if (valid_i[i] && (val_i[i] < min_o)) min_o = val_i[i];
    end
  end
endmodule

// File: rtl/mshr_entry.sv
module mshr_entry #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 8,
  parameter int CYC_W  = 16,
  parameter int REF_W  = 4,
  parameter int L1_LAT = 4,
  parameter int L2_LAT = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CYC_W-1:0]        cyc_i,
  input  logic [TAG_W-1:0]        retire_base_i,
  input  logic                    alloc_i,
  input  logic [ADDR_W-1:0]       alloc_line_i,
  input  logic [TAG_W-1:0]        alloc_pos_i,
  input  logic                    alloc_wait_i,
  input  logic                    alloc_l2hit_i,
  input  logic [CYC_W-1:0]        alloc_done_at_i,
  input  logic                    merge_i,
  input  logic                    rel_i,
  input  logic                    done_take_i,
  output logic                    busy_o,
  output logic [ADDR_W-1:0]       line_o,
  output logic signed [TAG_W+1:0] age_o,
  output logic [CYC_W-1:0]        rem_o,
  output logic                    due_o
);
  logic              busy_q, wait_q, l2hit_q, rep_q;
  logic [ADDR_W-1:0] line_q;
  logic [TAG_W-1:0]  pos_q;
  logic [CYC_W-1:0]  done_at_q, diff;
  logic [REF_W-1:0]  ref_q;
  logic              reached;

  mshr_age_fold #(.TAG_W(TAG_W)) i_age (
    .pos_i (pos_q),
    .base_i(retire_base_i),
    .age_o (age_o)
  );

  assign diff    = done_at_q - cyc_i;
  assign rem_o   = diff[CYC_W-1] ? '0 : diff;
  assign reached = (rem_o == '0);
  assign busy_o  = busy_q;
  assign line_o  = line_q;
  assign due_o   = busy_q && !wait_q && !rep_q && reached;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      wait_q    <= 1'b0;
      l2hit_q   <= 1'b0;
      rep_q     <= 1'b0;
      line_q    <= '0;
      pos_q     <= '0;
      done_at_q <= '0;
      ref_q     <= '0;
    end else if (alloc_i) begin
      busy_q    <= 1'b1;
      wait_q    <= alloc_wait_i;
      l2hit_q   <= alloc_l2hit_i;
      rep_q     <= 1'b0;
      line_q    <= alloc_line_i;
      pos_q     <= alloc_pos_i;
      done_at_q <= alloc_done_at_i;
      ref_q     <= REF_W'(1);
    end else if (busy_q) begin
      ref_q <= ref_q + REF_W'(merge_i) - REF_W'(rel_i);
      if (rel_i && !merge_i && ref_q == REF_W'(1)) busy_q <= 1'b0;
      if (wait_q && reached) begin
        // store wait over: start the L1 miss phase
        wait_q    <= 1'b0;
        done_at_q <= cyc_i + CYC_W'(L1_LAT) + (l2hit_q ? '0 : CYC_W'(L2_LAT));
      end
      if (done_take_i) rep_q <= 1'b1;
    end
  end
endmodule

// File: rtl/mshr_file.sv
module mshr_file #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 6,
  parameter int TAG_W   = 8,
  parameter int CYC_W   = 16,
  parameter int N_ENTRY = 8,
  parameter int REF_W   = 4,
  parameter int HIT_LAT = 1,
  parameter int L1_LAT  = 4,
  parameter int L2_LAT  = 12,
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [TAG_W-1:0]   req_tag_i,
  input  logic               req_first_i,
  input  logic               l1_hit_i,
  input  logic               l2_hit_i,
  input  logic               st_hit_i,
  input  logic [TAG_W+1:0]   st_age_i,
  input  logic [CYC_W-1:0]   st_done_at_i,
  input  logic [TAG_W-1:0]   retire_base_i,
  input  logic               rel_valid_i,
  input  logic [IDX_W-1:0]   rel_idx_i,
  output logic [1:0]         rsp_kind_o,
  output logic [IDX_W-1:0]   rsp_idx_o,
  output logic [CYC_W-1:0]   rsp_delay_o,
  output logic               done_o,
  output logic [IDX_W-1:0]   done_idx_o,
  output logic [ADDR_W-1:0]  done_addr_o
);
  import mshr_pkg::*;

  localparam int CNT_W = IDX_W + 1;
  localparam logic [ADDR_W-1:0] LINE_MASK = ~(ADDR_W'((2**OFF_W) - 1));

  logic [CYC_W-1:0]        cyc_q;
  logic [ADDR_W-1:0]       req_line;
  logic signed [TAG_W+1:0] req_age;
  logic [TAG_W-1:0]        alloc_pos;

  logic [N_ENTRY-1:0]      busy, match, due, alloc_vec, merge_vec, rel_vec, take_vec;
  logic [ADDR_W-1:0]       line_a [N_ENTRY];
  logic signed [TAG_W+1:0] age_a  [N_ENTRY];
  logic [CYC_W-1:0]        rem_a  [N_ENTRY];

  logic                    match_found, free_found, due_found;
  logic [IDX_W-1:0]        match_idx, free_idx, due_idx;
  logic [CYC_W-1:0]        min_rem;
  logic [CNT_W-1:0]        n_free;
  logic [CYC_W-1:0]        cyc_p1, st_late, alloc_done_at;
  logic                    alloc_wait;
  rsp_kind_e               kind;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else         cyc_q <= cyc_q + CYC_W'(1);
  end

  assign req_line  = req_addr_i & LINE_MASK;
  assign alloc_pos = req_tag_i + retire_base_i;

  mshr_age_fold #(.TAG_W(TAG_W)) i_req_age (
    .pos_i (req_tag_i),
    .base_i('0),
    .age_o (req_age)
  );

  for (genvar g = 0; g < N_ENTRY; g++) begin : g_ent
    assign match[g] = busy[g] && (line_a[g] == req_line) && (age_a[g] <= req_age) &&
                      !(st_hit_i && (age_a[g] < $signed(st_age_i)));
    assign rel_vec[g]  = rel_valid_i && (rel_idx_i == IDX_W'(g));
    assign take_vec[g] = due_found && (due_idx == IDX_W'(g));

    mshr_entry #(
      .ADDR_W(ADDR_W), .TAG_W(TAG_W), .CYC_W(CYC_W), .REF_W(REF_W),
      .L1_LAT(L1_LAT), .L2_LAT(L2_LAT)
    ) i_entry (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .cyc_i          (cyc_q),
      .retire_base_i  (retire_base_i),
      .alloc_i        (alloc_vec[g]),
      .alloc_line_i   (req_line),
      .alloc_pos_i    (alloc_pos),
      .alloc_wait_i   (alloc_wait),
      .alloc_l2hit_i  (l2_hit_i),
      .alloc_done_at_i(alloc_done_at),
      .merge_i        (merge_vec[g]),
      .rel_i          (rel_vec[g]),
      .done_take_i    (take_vec[g]),
      .busy_o         (busy[g]),
      .line_o         (line_a[g]),
      .age_o          (age_a[g]),
      .rem_o          (rem_a[g]),
      .due_o          (due[g])
    );
  end

  mshr_lsb_pick #(.N(N_ENTRY), .IW(IDX_W)) i_pick_match (
    .req_i(match), .found_o(match_found), .idx_o(match_idx));
  mshr_lsb_pick #(.N(N_ENTRY), .IW(IDX_W)) i_pick_free (
    .req_i(~busy), .found_o(free_found), .idx_o(free_idx));
  mshr_lsb_pick #(.N(N_ENTRY), .IW(IDX_W)) i_pick_due (
    .req_i(due), .found_o(due_found), .idx_o(due_idx));
  mshr_min_rem #(.N(N_ENTRY), .W(CYC_W)) i_min (
    .valid_i(busy), .val_i(rem_a), .min_o(min_rem));

  always_comb begin
    n_free = '0;
    for (int i = 0; i < N_ENTRY; i++) n_free = n_free + CNT_W'(!busy[i]);
  end

  // conflicted loads wait until the last older store lands
  assign alloc_wait = st_hit_i;
  assign cyc_p1     = cyc_q + CYC_W'(1);
  assign st_late    = st_done_at_i - cyc_p1;
  always_comb begin
    if (st_hit_i)
      alloc_done_at = st_late[CYC_W-1] ? cyc_p1 : st_done_at_i;
    else
      alloc_done_at = cyc_q + CYC_W'(L1_LAT) + (l2_hit_i ? '0 : CYC_W'(L2_LAT));
  end

  always_comb begin
    kind        = RSP_HIT;
    rsp_idx_o   = '0;
    rsp_delay_o = CYC_W'(HIT_LAT);
    alloc_vec   = '0;
    merge_vec   = '0;
    if (st_hit_i || !l1_hit_i) begin
      if (match_found) begin
        kind                 = RSP_MERGE;
        rsp_idx_o            = match_idx;
        rsp_delay_o          = rem_a[match_idx];
        merge_vec[match_idx] = req_valid_i;
      end else if (!free_found || (!req_first_i && n_free <= CNT_W'(1))) begin
        kind        = RSP_ABORT;
        rsp_delay_o = min_rem;
      end else begin
        kind                = RSP_ALLOC;
        rsp_idx_o           = free_idx;
        rsp_delay_o         = alloc_done_at - cyc_q;
        alloc_vec[free_idx] = req_valid_i;
      end
    end
  end

  assign rsp_kind_o  = kind;
  assign done_o      = due_found;
  assign done_idx_o  = due_idx;
  assign done_addr_o = line_a[due_idx];
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
  parameter int N_ENTRY = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_first_i,
  input logic               st_hit_i,
  input logic [1:0]         rsp_kind_i,
  input logic [IDX_W-1:0]   rsp_idx_i,
  input logic               done_i,
  input logic [IDX_W-1:0]   done_idx_i,
  input logic [N_ENTRY-1:0] busy_i
);
  localparam logic [1:0] K_HIT   = 2'd0;
  localparam logic [1:0] K_ALLOC = 2'd2;
  localparam logic [1:0] K_ABORT = 2'd3;

  a_r5_no_hit_on_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && st_hit_i |-> rsp_kind_i != K_HIT);

  a_r6_alloc_from_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && rsp_kind_i == K_ALLOC |-> !busy_i[rsp_idx_i]);

  a_r6_alloc_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && rsp_kind_i == K_ALLOC |=> busy_i[$past(rsp_idx_i)]);

  a_r7_reissue_keeps_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_first_i && $countones(busy_i) >= N_ENTRY-1 |-> rsp_kind_i != K_ALLOC);

  a_r8_abort_only_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && rsp_kind_i == K_ABORT |-> $countones(busy_i) >= N_ENTRY-1);

  a_r11_done_from_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> busy_i[done_idx_i]);

  a_r11_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && $past(done_i) |-> done_idx_i != $past(done_idx_i));
endmodule

bind mshr_file mshr_file_chk #(.N_ENTRY(N_ENTRY), .IDX_W(IDX_W)) i_mshr_file_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_first_i(req_first_i),
  .st_hit_i   (st_hit_i),
  .rsp_kind_i (rsp_kind_o),
  .rsp_idx_i  (rsp_idx_o),
  .done_i     (done_o),
  .done_idx_i (done_idx_o),
  .busy_i     (busy)
);

// File: tb/test_mshr_file.sv
module test_mshr_file;
  localparam int ADDR_W = 32;
  localparam int TAG_W  = 8;
  localparam int CYC_W  = 16;
  localparam int IDX_W  = 3;

  typedef struct packed {
    logic        first;
    logic [31:0] addr;
    logic [7:0]  tag;
    logic        l1;
    logic        l2;
    logic [1:0]  kind;
    logic [2:0]  idx;
    logic [15:0] dly;
  } vec_t;

  // one request per cycle, retire base 0, no store conflict
  localparam vec_t VEC [7] = '{
    '{1'b1, 32'h0000_1000, 8'd5,   1'b1, 1'b0, 2'd0, 3'd0, 16'd1},  // R2 hit
    '{1'b1, 32'h0000_1004, 8'd6,   1'b0, 1'b1, 2'd2, 3'd0, 16'd4},  // R6 alloc l2 hit
    '{1'b1, 32'h0000_1038, 8'd7,   1'b0, 1'b0, 2'd1, 3'd0, 16'd3},  // R1 R3 merge same line
    '{1'b1, 32'h0000_2000, 8'd8,   1'b0, 1'b0, 2'd2, 3'd1, 16'd16}, // R6 alloc l2 miss
    '{1'b1, 32'h0000_1000, 8'd3,   1'b0, 1'b1, 2'd2, 3'd2, 16'd4},  // R3 older load no merge
    '{1'b1, 32'h0000_2010, 8'd9,   1'b0, 1'b0, 2'd1, 3'd1, 16'd14}, // R3 merge remaining
    '{1'b1, 32'h0000_2000, 8'd250, 1'b0, 1'b0, 2'd2, 3'd3, 16'd16}  // R4 negative age
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid, req_first, l1_hit, l2_hit, st_hit, rel_valid;
  logic [ADDR_W-1:0] req_addr;
  logic [TAG_W-1:0]  req_tag, retire_base;
  logic [TAG_W+1:0]  st_age;
  logic [CYC_W-1:0]  st_done_at;
  logic [IDX_W-1:0]  rel_idx;
  logic [1:0]        rsp_kind;
  logic [IDX_W-1:0]  rsp_idx, done_idx;
  logic [CYC_W-1:0]  rsp_delay;
  logic              done;
  logic [ADDR_W-1:0] done_addr;

  int n_chk = 0;
  int n_err = 0;
  int bench_cyc;
  int c0;

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) bench_cyc <= 0;
    else        bench_cyc <= bench_cyc + 1;
  end

  mshr_file i_mshr_file (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_tag_i(req_tag),
    .req_first_i(req_first), .l1_hit_i(l1_hit), .l2_hit_i(l2_hit),
    .st_hit_i(st_hit), .st_age_i(st_age), .st_done_at_i(st_done_at),
    .retire_base_i(retire_base), .rel_valid_i(rel_valid), .rel_idx_i(rel_idx),
    .rsp_kind_o(rsp_kind), .rsp_idx_o(rsp_idx), .rsp_delay_o(rsp_delay),
    .done_o(done), .done_idx_o(done_idx), .done_addr_o(done_addr)
  );

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0; req_first = 1'b1; l1_hit = 1'b0; l2_hit = 1'b1;
    st_hit = 1'b0; st_age = '0; st_done_at = '0; rel_valid = 1'b0; rel_idx = '0;
    req_addr = '0; req_tag = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    idle();
    retire_base = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12", "done during reset", 32'(done), 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic drive(input logic first, input logic [31:0] addr, input logic [7:0] tag,
                       input logic l1, input logic l2);
    req_valid = 1'b1; req_first = first; req_addr = addr; req_tag = tag;
    l1_hit = l1; l2_hit = l2;
  endtask

  task automatic expect_rsp(input string r, input logic [1:0] kind, input logic [2:0] idx,
                            input logic [15:0] dly);
    #2;
    chk(r, "kind", 32'(rsp_kind), 32'(kind));
    if (kind == 2'd1 || kind == 2'd2) chk(r, "idx", 32'(rsp_idx), 32'(idx));
    chk(r, "delay", 32'(rsp_delay), 32'(dly));
  endtask

  task automatic wait_to(input int target);
    while (bench_cyc < target) tick();
  endtask

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    idle();
    retire_base = '0;
    @(negedge clk);

    // table walk
    do_reset();
    chk("R12", "done after reset", 32'(done), 32'd0);
    for (int i = 0; i < 7; i++) begin
      drive(VEC[i].first, VEC[i].addr, VEC[i].tag, VEC[i].l1, VEC[i].l2);
      expect_rsp($sformatf("vec%0d R2 R3 R6", i), VEC[i].kind, VEC[i].idx, VEC[i].dly);
      tick();
    end

    // R11 R1: done pulse timing and line address
    do_reset();
    c0 = bench_cyc;
    drive(1'b1, 32'h0000_4020, 8'd1, 1'b0, 1'b1);
    expect_rsp("R12 R6 first alloc at idx0", 2'd2, 3'd0, 16'd4);
    tick();
    wait_to(c0 + 3);
    chk("R11", "done early", 32'(done), 32'd0);
    wait_to(c0 + 4);
    chk("R11", "done pulse", 32'(done), 32'd1);
    chk("R11", "done idx", 32'(done_idx), 32'd0);
    chk("R1", "done addr aligned", done_addr, 32'h0000_4000);
    wait_to(c0 + 5);
    chk("R11", "done one cycle", 32'(done), 32'd0);

    // R9 R10: reference counting and deferred free
    do_reset();
    drive(1'b1, 32'h0000_3000, 8'd1, 1'b0, 1'b1);
    expect_rsp("R9 alloc", 2'd2, 3'd0, 16'd4);
    tick();
    drive(1'b1, 32'h0000_3008, 8'd2, 1'b0, 1'b1);
    expect_rsp("R9 merge", 2'd1, 3'd0, 16'd3);
    tick();
    rel_valid = 1'b1; rel_idx = 3'd0;
    tick();
    drive(1'b1, 32'h0000_3000, 8'd3, 1'b0, 1'b1);
    expect_rsp("R9 still held after one release", 2'd1, 3'd0, 16'd1);
    tick();
    rel_valid = 1'b1; rel_idx = 3'd0;
    tick();
    rel_valid = 1'b1; rel_idx = 3'd0;
    drive(1'b1, 32'h0000_5000, 8'd4, 1'b0, 1'b1);
    expect_rsp("R10 freed entry not reused same cycle", 2'd2, 3'd1, 16'd4);
    tick();
    drive(1'b1, 32'h0000_3000, 8'd5, 1'b0, 1'b1);
    expect_rsp("R9 R10 freed entry reused next cycle", 2'd2, 3'd0, 16'd4);
    tick();

    // R7 R8: full file, re-issue rule, abort delay
    do_reset();
    for (int i = 0; i < 7; i++) begin
      drive(1'b1, 32'h0001_0000 + 32'(i * 64), 8'(i), 1'b0, 1'b0);
      expect_rsp("R6 fill", 2'd2, 3'(i), 16'd16);
      tick();
    end
    drive(1'b0, 32'h0002_0000, 8'd8, 1'b0, 1'b0);
    expect_rsp("R7 R8 reissue refused last entry", 2'd3, 3'd0, 16'd9);
    tick();
    drive(1'b1, 32'h0002_0000, 8'd8, 1'b0, 1'b0);
    expect_rsp("R7 first issue takes last entry", 2'd2, 3'd7, 16'd16);
    tick();
    drive(1'b1, 32'h0003_0000, 8'd9, 1'b0, 1'b0);
    expect_rsp("R8 full abort nearest", 2'd3, 3'd0, 16'd7);
    tick();

    // R5 R3: store conflicts
    do_reset();
    c0 = bench_cyc;
    drive(1'b1, 32'h0000_9000, 8'd10, 1'b1, 1'b1);
    st_hit = 1'b1; st_age = 10'd10; st_done_at = 16'(c0 + 6);
    expect_rsp("R5 no hit under store", 2'd2, 3'd0, 16'd6);
    tick();
    drive(1'b1, 32'h0000_9010, 8'd12, 1'b0, 1'b1);
    st_hit = 1'b1; st_age = 10'd11; st_done_at = 16'(c0 + 7);
    expect_rsp("R3 R5 skip entry older than store", 2'd2, 3'd1, 16'd6);
    tick();
    drive(1'b1, 32'h0000_9020, 8'd12, 1'b0, 1'b1);
    st_hit = 1'b1; st_age = 10'd9; st_done_at = 16'(c0 + 7);
    expect_rsp("R3 merge into waiting entry", 2'd1, 3'd0, 16'd4);
    tick();
    wait_to(c0 + 6);
    chk("R5", "no done at wait end", 32'(done), 32'd0);
    wait_to(c0 + 10);
    chk("R5", "done after wait plus L1", 32'(done), 32'd1);
    chk("R5", "done idx", 32'(done_idx), 32'd0);
    wait_to(c0 + 11);
    chk("R11", "second entry done", 32'(done), 32'd1);
    chk("R11", "second entry idx", 32'(done_idx), 32'd1);

    // R4: tag window and wrap
    do_reset();
    retire_base = 8'd0;
    drive(1'b1, 32'h0000_7000, 8'd100, 1'b0, 1'b1);
    expect_rsp("R4 alloc", 2'd2, 3'd0, 16'd4);
    tick();
    retire_base = 8'd90;
    drive(1'b1, 32'h0000_7000, 8'd20, 1'b0, 1'b1);
    expect_rsp("R4 rebased entry older merges", 2'd1, 3'd0, 16'd3);
    tick();
    drive(1'b1, 32'h0000_7000, 8'd5, 1'b0, 1'b1);
    expect_rsp("R4 rebased entry newer no merge", 2'd2, 3'd1, 16'd4);
    tick();
    retire_base = 8'd250;
    drive(1'b1, 32'h0000_8000, 8'd10, 1'b0, 1'b1);
    expect_rsp("R4 alloc across wrap", 2'd2, 3'd2, 16'd4);
    tick();
    retire_base = 8'd2;
    drive(1'b1, 32'h0000_8000, 8'd1, 1'b0, 1'b1);
    expect_rsp("R4 wrapped entry newer", 2'd2, 3'd3, 16'd4);
    tick();
    drive(1'b1, 32'h0000_8000, 8'd3, 1'b0, 1'b1);
    expect_rsp("R4 wrapped entry older merges", 2'd1, 3'd2, 16'd2);
    tick();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule